// File: doc/BRIEF.md
# PHY Basic Control Register and Operating-Mode Resolver

This block holds the basic control register of a 10/100 Ethernet PHY's management space at register address 0. It turns the stored bits, three strap pins and the results of an external auto-negotiation engine into the controls the rest of the PHY runs on. Those controls are the effective link speed, the duplex mode, the auto-negotiation enable, the loopback enable, the enables for the line transmitter and receiver, and the collision-detect enable.

A strap pin selects between two modes, and the mode decides who owns the rate and auto-negotiation choices. In hardware mode the rate and auto-negotiation pins own them. In software mode the register bits own them, unless auto-negotiation is on; then the negotiated result owns both. When loopback is set, the analog line functions are switched off. A short fixed pipeline then returns the MAC transmit stream on the MAC receive side, and line receive activity is hidden.

Top module: `phyctl_top`

## Requirements
- R1: After reset the register at address 0 reads 16'h1000, with only the auto-negotiation bit (bit 12) set. The effective controls then follow the auto-negotiated result, with the transmitter, receiver and collision detect enabled.
- R2: A write to address 0 stores only bit 14 (loopback), bit 13 (rate, 1 = 100 Mb/s), bit 12 (auto-negotiation), bit 8 (duplex, 1 = full) and bit 7 (collision override). Every other bit reads as zero. Writes to any other address change nothing, and reads of any other address return zero.
- R3: With the mode pin low (hardware mode), bits 13 and 12 read as zero. The effective speed then equals the synchronized rate pin, and the effective auto-negotiation enable equals the synchronized auto-negotiation pin.
- R4: With the mode pin high and bit 12 set, auto-negotiation is enabled. Speed and duplex then come from the negotiated inputs, and bits 13 and 8 have no effect.
- R5: With the mode pin high and bit 12 clear, bit 13 gives the speed and bit 8 gives the duplex.
- R6: In hardware mode, the duplex comes from the negotiated input when the auto-negotiation pin is high, and from bit 8 otherwise.
- R7: While bit 14 is set, the transmitter enable and the receiver enable are low, and the line transmit enable output is forced low. Collision detect is enabled only if bit 7 is set. While bit 14 is clear, collision detect is enabled.
- R8: While loopback is active, the MAC receive valid and data equal the MAC transmit enable and data from two clock edges earlier. Line receive inputs are ignored.
- R9: While loopback is inactive, the MAC receive valid and data equal the line receive inputs in the same cycle. The line transmit enable follows the MAC transmit enable.
- R10: The link-rate status output is high only when the link-up input is high and the effective speed is 100 Mb/s.
- R11: The effective controls change on the clock edge after the edge that writes the register. A strap pin change reaches them on the third edge, because of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pin_sw_mode | input | 1 | Mode strap: 1 software, 0 hardware |
| pin_rate | input | 1 | Rate strap, 1 = 100 Mb/s |
| pin_an_sel | input | 1 | Auto-negotiation strap |
| neg_speed100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_full_dup | input | 1 | Negotiated duplex, 1 = full |
| link_up | input | 1 | Link active indication |
| eff_speed100 | output | 1 | Effective speed |
| eff_full_dup | output | 1 | Effective duplex |
| eff_an_en | output | 1 | Effective auto-negotiation enable |
| eff_loopback | output | 1 | Effective loopback |
| xmtr_en | output | 1 | Line transmitter enable |
| rcvr_en | output | 1 | Line receiver enable |
| col_det_en | output | 1 | Collision detect enable |
| link_rate100 | output | 1 | Rate of the active link |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_txd | input | 4 | MAC transmit data |
| mac_rx_dv | output | 1 | MAC receive valid |
| mac_rxd | output | 4 | MAC receive data |
| line_rx_dv | input | 1 | Receive valid from the line side |
| line_rxd | input | 4 | Receive data from the line side |
| line_tx_en | output | 1 | Transmit enable to the line side |
| line_txd | output | 4 | Transmit data to the line side |

## Verification
The assertions assume that the negotiated inputs, the link indication and the MAC signals are already synchronous to clk. They also assume that only the strap pins arrive asynchronously. The stimulus therefore changes every input only in the half cycle after a falling edge, so a strap change enters the synchronizer on a known edge. It also holds the MAC transmit enable low through reset, so that the two-edge loopback relation has a clean history from the first cycle.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int MII_W    = 4;
    localparam int SYNC_STG = 2;
    localparam int LOOP_DLY = 2;

    // bit positions decoded by the resolver
    localparam int B_LOOP   = 14;
    localparam int B_RATE   = 13;
    localparam int B_AUTO   = 12;
    localparam int B_DUPLEX = 8;
    localparam int B_COLTST = 7;

    localparam logic [REG_W-1:0] WR_MASK =
        (16'h1 << B_LOOP) | (16'h1 << B_RATE) | (16'h1 << B_AUTO) |
        (16'h1 << B_DUPLEX) | (16'h1 << B_COLTST);
    localparam logic [REG_W-1:0] CTRL_RST = 16'h1 << B_AUTO;

    typedef struct packed {
        logic sw_mode;
        logic rate_sel;
        logic an_sel;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    typedef struct packed {
        logic speed100;
        logic full_dup;
        logic an_en;
        logic loopback;
        logic xmtr_en;
        logic rcvr_en;
        logic col_en;
    } eff_ctrl_t;

    localparam eff_ctrl_t EFF_RST = '{speed100: 1'b0, full_dup: 1'b0, an_en: 1'b0,
                                      loopback: 1'b0, xmtr_en: 1'b1, rcvr_en: 1'b1,
                                      col_en: 1'b1};

    // bits owned by the straps read as zero in hardware mode
    function automatic logic [REG_W-1:0] read_view(input logic [REG_W-1:0] r,
                                                   input logic sw);
        logic [REG_W-1:0] v;
        v = r;
        if (!sw) begin
            v[B_RATE] = 1'b0;
            v[B_AUTO] = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/phyctl_sync.sv
module phyctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/phyctl_regfile.sv
module phyctl_regfile
    import phyctl_pkg::*;
#(
    parameter int               AW      = ADDR_W,
    parameter logic [AW-1:0]    MY_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             sw_mode,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] store;
    logic             hit;

    assign hit = (addr == MY_ADDR);

    always_ff @(posedge clk) begin
        if (rst)               store <= CTRL_RST;
        else if (wr_en && hit) store <= wdata & WR_MASK;
    end

    assign ctrl  = store;
    assign rdata = hit ? read_view(store, sw_mode) : '0;

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (store == ($past(wdata) & WR_MASK)));

    // R2
    wr_other_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && hit)) |=> $stable(store));
endmodule

// File: rtl/phyctl_resolve.sv
module phyctl_resolve
    import phyctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctrl,
    input  strap_t           st,
    input  logic             neg_speed100,
    input  logic             neg_full_dup,
    output eff_ctrl_t        eff
);
    eff_ctrl_t nx;

    always_comb begin
        nx = EFF_RST;
        if (!st.sw_mode) begin
            nx.an_en    = st.an_sel;
            nx.speed100 = st.rate_sel;
            nx.full_dup = st.an_sel ? neg_full_dup : ctrl[B_DUPLEX];
        end else if (ctrl[B_AUTO]) begin
            nx.an_en    = 1'b1;
            nx.speed100 = neg_speed100;
            nx.full_dup = neg_full_dup;
        end else begin
            nx.an_en    = 1'b0;
            nx.speed100 = ctrl[B_RATE];
            nx.full_dup = ctrl[B_DUPLEX];
        end
        nx.loopback = ctrl[B_LOOP];
        nx.xmtr_en  = !ctrl[B_LOOP];
        nx.rcvr_en  = !ctrl[B_LOOP];
        nx.col_en   = !ctrl[B_LOOP] || ctrl[B_COLTST];
    end

    always_ff @(posedge clk) begin
        if (rst) eff <= EFF_RST;
        else     eff <= nx;
    end

    // R3
    hw_strap_chk: assert property (@(posedge clk) disable iff (rst)
        !st.sw_mode |=> (eff.speed100 == $past(st.rate_sel)) && (eff.an_en == $past(st.an_sel)));

    // R4
    sw_auto_chk: assert property (@(posedge clk) disable iff (rst)
        (st.sw_mode && ctrl[B_AUTO]) |=> eff.an_en && (eff.speed100 == $past(neg_speed100))
                                         && (eff.full_dup == $past(neg_full_dup)));

    // R5
    sw_manual_chk: assert property (@(posedge clk) disable iff (rst)
        (st.sw_mode && !ctrl[B_AUTO]) |=> !eff.an_en && (eff.speed100 == $past(ctrl[B_RATE]))
                                          && (eff.full_dup == $past(ctrl[B_DUPLEX])));

    // R7
    loop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[B_LOOP] |=> !eff.xmtr_en && !eff.rcvr_en && (eff.col_en == $past(ctrl[B_COLTST])));
endmodule

// File: rtl/phyctl_loop.sv
module phyctl_loop
    import phyctl_pkg::*;
#(
    parameter int DW = MII_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lb_i,
    input  logic          tx_en_i,
    input  logic [DW-1:0] txd_i,
    input  logic          line_dv_i,
    input  logic [DW-1:0] line_d_i,
    output logic          rx_dv_o,
    output logic [DW-1:0] rxd_o
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } beat_t;

    beat_t pipe [LOOP_DLY];

    genvar g;
    generate
        for (g = 0; g < LOOP_DLY; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[g] <= '0;
                end else if (g == 0) begin
                    pipe[g] <= '{v: tx_en_i, d: txd_i};
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign rx_dv_o = lb_i ? pipe[LOOP_DLY-1].v : line_dv_i;
    assign rxd_o   = lb_i ? pipe[LOOP_DLY-1].d : line_d_i;

    // R8
    loop_delay_chk: assert property (@(posedge clk) disable iff (rst)
        lb_i |-> (rx_dv_o == $past(tx_en_i, 2)) && (rxd_o == $past(txd_i, 2)));
endmodule

// File: rtl/phyctl_top.sv
module phyctl_top
    import phyctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pin_sw_mode,
    input  logic              pin_rate,
    input  logic              pin_an_sel,
    input  logic              neg_speed100,
    input  logic              neg_full_dup,
    input  logic              link_up,
    output logic              eff_speed100,
    output logic              eff_full_dup,
    output logic              eff_an_en,
    output logic              eff_loopback,
    output logic              xmtr_en,
    output logic              rcvr_en,
    output logic              col_det_en,
    output logic              link_rate100,
    input  logic              mac_tx_en,
    input  logic [MII_W-1:0]  mac_txd,
    output logic              mac_rx_dv,
    output logic [MII_W-1:0]  mac_rxd,
    input  logic              line_rx_dv,
    input  logic [MII_W-1:0]  line_rxd,
    output logic              line_tx_en,
    output logic [MII_W-1:0]  line_txd
);
    strap_t           st_raw, st;
    logic [REG_W-1:0] ctrl;
    eff_ctrl_t        eff;

    assign st_raw = '{sw_mode: pin_sw_mode, rate_sel: pin_rate, an_sel: pin_an_sel};

    phyctl_sync #(.W(STRAP_W), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (st_raw),
        .q   (st)
    );

    phyctl_regfile #(.AW(ADDR_W), .MY_ADDR('0)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sw_mode (st.sw_mode),
        .ctrl    (ctrl),
        .rdata   (reg_rdata)
    );

    phyctl_resolve u_res (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .st           (st),
        .neg_speed100 (neg_speed100),
        .neg_full_dup (neg_full_dup),
        .eff          (eff)
    );

    phyctl_loop #(.DW(MII_W)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .lb_i      (eff.loopback),
        .tx_en_i   (mac_tx_en),
        .txd_i     (mac_txd),
        .line_dv_i (line_rx_dv),
        .line_d_i  (line_rxd),
        .rx_dv_o   (mac_rx_dv),
        .rxd_o     (mac_rxd)
    );

    assign eff_speed100 = eff.speed100;
    assign eff_full_dup = eff.full_dup;
    assign eff_an_en    = eff.an_en;
    assign eff_loopback = eff.loopback;
    assign xmtr_en      = eff.xmtr_en;
    assign rcvr_en      = eff.rcvr_en;
    assign col_det_en   = eff.col_en;
    assign link_rate100 = link_up && eff.speed100;
    assign line_tx_en   = mac_tx_en && eff.xmtr_en;
    assign line_txd     = mac_txd;

    // R7
    line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl[B_LOOP]) |-> !line_tx_en);

    // R10
    rate_status_chk: assert property (@(posedge clk) disable iff (rst)
        link_rate100 |-> (link_up && eff_speed100));
endmodule

// File: tb/test_phyctl_top.sv
module test_phyctl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pin_sw_mode = 1'b1, pin_rate = 1'b0, pin_an_sel = 1'b0;
    logic        neg_speed100 = 1'b1, neg_full_dup = 1'b1, link_up = 1'b0;
    logic        eff_speed100, eff_full_dup, eff_an_en, eff_loopback;
    logic        xmtr_en, rcvr_en, col_det_en, link_rate100;
    logic        mac_tx_en = 1'b0;
    logic [3:0]  mac_txd = '0;
    logic        mac_rx_dv;
    logic [3:0]  mac_rxd;
    logic        line_rx_dv = 1'b0;
    logic [3:0]  line_rxd = '0;
    logic        line_tx_en;
    logic [3:0]  line_txd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    phyctl_top i_phyctl_top (.*);

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t sb[$];

    // sel: 0 rdata, 1 {speed,dup,an,lb,xmtr,rcvr,col}, 2 {rx_dv,rxd}, 3 link_rate100, 4 line_tx_en
    function automatic logic [15:0] observe(int sel);
        case (sel)
            0: return reg_rdata;
            1: return {9'd0, eff_speed100, eff_full_dup, eff_an_en, eff_loopback,
                       xmtr_en, rcvr_en, col_det_en};
            2: return {11'd0, mac_rx_dv, mac_rxd};
            3: return {15'd0, link_rate100};
            default: return {15'd0, line_tx_en};
        endcase
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic push(string req, int sel, logic [15:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic sync_n();
        @(negedge clk); #2;
    endtask

    // write happens on the next rising edge; returns just after it
    task automatic wr(logic [4:0] a, logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = '0;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        edges(4);
        // R1 reset value and auto-negotiated effective controls
        push("R1", 0, 16'h1000);
        push("R1", 1, 16'b1110111);
        sync_n();

        // R2 only the defined bits store; R11 effect one edge later
        wr(5'd0, 16'hFFFF);
        push("R2", 0, 16'h7180);
        push("R11", 1, 16'b1110111);
        sync_n();
        edges(1);
        push("R11", 1, 16'b1111001);
        push("R7", 1, 16'b1111001);
        sync_n();

        // R2 other address: write ignored, read zero
        wr(5'd3, 16'h0000);
        push("R2", 0, 16'h7180);
        sync_n();
        reg_addr = 5'd3;
        #1 push("R2", 0, 16'h0000);
        sync_n();
        reg_addr = 5'd0;

        // R7 loopback without collision override
        wr(5'd0, 16'h4000);
        edges(1);
        push("R7", 1, 16'b0001000);
        sync_n();

        // R8 loopback path, line receive ignored
        mac_tx_en = 1'b1; mac_txd = 4'h5; line_rx_dv = 1'b1; line_rxd = 4'hA;
        edges(1);
        push("R8", 2, 16'h0000);
        push("R7", 4, 16'h0000);
        sync_n();
        edges(1);
        push("R8", 2, 16'h0015);
        sync_n();
        mac_tx_en = 1'b0; mac_txd = 4'h0;
        edges(1);
        push("R8", 2, 16'h0015);
        sync_n();
        edges(1);
        push("R8", 2, 16'h0000);
        sync_n();

        // R9 pass-through when loopback cleared
        wr(5'd0, 16'h0000);
        edges(1);
        push("R9", 1, 16'b0000111);
        push("R9", 2, 16'h001A);
        sync_n();
        mac_tx_en = 1'b1;
        #1 push("R9", 4, 16'h0001);
        sync_n();
        mac_tx_en = 1'b0; line_rx_dv = 1'b0;

        // R5 manual rate and duplex
        wr(5'd0, 16'h2100);
        edges(1);
        push("R5", 1, 16'b1100111);
        sync_n();
        wr(5'd0, 16'h2000);
        edges(1);
        push("R5", 1, 16'b1000111);
        sync_n();

        // R4 auto-negotiation result used, bits 13 and 8 ignored
        neg_speed100 = 1'b0; neg_full_dup = 1'b1;
        wr(5'd0, 16'h1000);
        edges(1);
        push("R4", 1, 16'b0110111);
        sync_n();
        neg_full_dup = 1'b0;
        wr(5'd0, 16'h3100);
        edges(1);
        push("R4", 1, 16'b0010111);
        sync_n();

        // R10 link rate status
        link_up = 1'b1;
        #1 push("R10", 3, 16'h0000);
        sync_n();
        neg_speed100 = 1'b1;
        edges(1);
        push("R10", 3, 16'h0001);
        sync_n();
        link_up = 1'b0;
        #1 push("R10", 3, 16'h0000);
        sync_n();

        // R3 / R11 hardware mode: strap change lands on third edge
        pin_sw_mode = 1'b0; pin_rate = 1'b1; pin_an_sel = 1'b0;
        edges(2);
        push("R11", 1, 16'b1010111);
        sync_n();
        edges(1);
        push("R3", 1, 16'b1100111);
        push("R6", 1, 16'b1100111);
        push("R3", 0, 16'h0100);
        sync_n();

        // R6 auto-negotiation pin on: duplex from negotiation
        pin_an_sel = 1'b1;
        edges(3);
        push("R6", 1, 16'b1010111);
        sync_n();
        pin_rate = 1'b0;
        edges(3);
        push("R3", 1, 16'b0010111);
        sync_n();
        wr(5'd0, 16'h2100);
        push("R3", 0, 16'h0100);
        sync_n();

        // back to software mode: bit 12 clear, bits 13/8 rule
        pin_sw_mode = 1'b1;
        edges(3);
        push("R5", 1, 16'b1100111);
        push("R2", 0, 16'h2100);
        sync_n();

        sync_n();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule